// File: doc/BRIEF.md
# Processor Trap Entry Sequencer

This block carries out the hardware side of entering a trap on a 32-bit core with register windows. The pipeline presents a trap request with an 8-bit trap type together with the current architectural state: the trap-enable bit, the supervisor bit, the window pointer, the trap base register, the two program counters and the cache-control state field. One clock later the block returns the complete post-trap state in a single step. That state is traps disabled, supervisor mode with the old mode saved, the window rotated down by one, the vector address loaded into the trap base register and the PC, and the next-PC one word beyond it.

In the same cycle it writes the interrupted PC and next-PC into registers 9 and 10 of the new window through a two-lane register-file write port. It acknowledges external interrupts to the interrupt controller with their level. When the per-cache freeze flags are set, it freezes any cache that is enabled. A trap that arrives while traps are already disabled is not taken. The block instead latches an error mode, or a shutdown request when the trap type is 0x80 and the halt feature is configured. Either condition lasts until reset, and every later request is ignored.

Top module: `trap_entry_seq`

## Requirements
- R1: While reset is active and after its release, until the first taken trap, `s_o`=1, `et_o`=0, `cwp_o`=0, and all other outputs read 0, except the constant register indices.
- R2: A request sampled with `et_i`=1 raises `trap_taken` for exactly the next cycle, and in that cycle `et_o`=0.
- R3: On a taken trap `cwp_o` equals `cwp_i`-1, and `cwp_i`=0 wraps to NWIN-1.
- R4: On a taken trap `rf_we` pulses with `rf_win` equal to the new window pointer. Lane A writes `pc_i` to index 9 (`rf_addr_a`=9) and lane B writes `npc_i` to index 10 (`rf_addr_b`=10).
- R5: On a taken trap `ps_o` takes the sampled `s_i` and `s_o` becomes 1.
- R6: On a taken trap `tbr_o` = {`tbr_i`[31:12], `trap_type`, 4'h0}, `pc_o` = `tbr_o` and `npc_o` = `tbr_o` + 4.
- R7: If `trap_type`[7:4] = 4'h1, the taken trap also pulses `irq_ack` with `irq_level` = `trap_type`[3:0]. Any other type gives no acknowledge.
- R8: `cctl_o`[1:0] is the instruction cache state and `cctl_o`[3:2] is the data cache state, where 2'b11 means enabled and 2'b01 means frozen. On a taken interrupt trap, a field that holds 2'b11 becomes 2'b01 when its flag is set (`ifrz_i` for the instruction field, `dfrz_i` for the data field). Every other field, and every field on a non-interrupt trap, is copied from `cctl_i` unchanged.
- R9: A request sampled with `et_i`=0 takes no trap and sets `error_mode`. When the trap type is 0x80 and `halt_ta0_i`=1, it sets `shutdown_req` instead.
- R10: Once `error_mode` or `shutdown_req` is set, it stays set until reset. Later requests raise no strobe and change no output.
- R11: Without a request, all state outputs hold their values and the strobes stay low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| trap_req | input | 1 | Trap request, sampled every cycle |
| trap_type | input | 8 | Trap type of the request |
| halt_ta0_i | input | 1 | Feature: type 0x80 with traps disabled requests shutdown |
| et_i | input | 1 | Current trap-enable bit |
| s_i | input | 1 | Current supervisor bit |
| cwp_i | input | CWPW | Current window pointer |
| tbr_i | input | XLEN | Current trap base register |
| pc_i | input | XLEN | Interrupted PC |
| npc_i | input | XLEN | Interrupted next-PC |
| cctl_i | input | 4 | Current cache state fields |
| ifrz_i | input | 1 | Freeze instruction cache on interrupt |
| dfrz_i | input | 1 | Freeze data cache on interrupt |
| trap_taken | output | 1 | One-cycle strobe: trap entered |
| et_o | output | 1 | New trap-enable bit |
| s_o | output | 1 | New supervisor bit |
| ps_o | output | 1 | New previous-supervisor bit |
| cwp_o | output | CWPW | New window pointer |
| tbr_o | output | XLEN | New trap base register |
| pc_o | output | XLEN | New PC |
| npc_o | output | XLEN | New next-PC |
| cctl_o | output | 4 | New cache state fields |
| rf_we | output | 1 | Register-file write strobe, both lanes |
| rf_win | output | CWPW | Window addressed by the write |
| rf_addr_a | output | RFAW | Lane A register index (9) |
| rf_data_a | output | XLEN | Lane A data (interrupted PC) |
| rf_addr_b | output | RFAW | Lane B register index (10) |
| rf_data_b | output | XLEN | Lane B data (interrupted next-PC) |
| irq_ack | output | 1 | Interrupt acknowledge strobe |
| irq_level | output | 4 | Level being acknowledged |
| error_mode | output | 1 | Trap with traps disabled; held until reset |
| shutdown_req | output | 1 | Halt-feature shutdown; held until reset |

## Verification
The window-pointer property assumes `cwp_i` is always below NWIN, and the acknowledge property assumes the trap type is steady for the whole cycle it is sampled in. The bench changes every input only on the falling edge. It draws window pointers modulo NWIN and includes 0, so the wrap case is always exercised. The error and shutdown paths are each driven from a fresh reset, because both conditions are permanent once set.

// File: rtl/trap_pkg.sv
package trap_pkg;
  localparam logic [1:0] CST_ENABLED = 2'b11;
  localparam logic [1:0] CST_FROZEN  = 2'b01;
  localparam logic [3:0] IRQ_GROUP   = 4'h1;
  localparam logic [7:0] TT_HALT     = 8'h80;
  localparam int         RF_IDX_PC   = 9;
  localparam int         RF_IDX_NPC  = 10;
  localparam int         NCACHE      = 2;
  localparam int         CST_W       = 2;
  typedef logic [CST_W-1:0] cstate_t;
endpackage

// File: rtl/trap_cwp_dec.sv
module trap_cwp_dec #(
  parameter int NWIN = 8,
  parameter int CWPW = 3
) (
  input  logic [CWPW-1:0] cwp_in,
  output logic [CWPW-1:0] cwp_out
);
  localparam bit POW2 = ((NWIN & (NWIN - 1)) == 0);

  generate
    if (POW2) begin : g_pow2
      // wrap falls out of the natural modulo of the field width
      assign cwp_out = cwp_in - CWPW'(1);
    end else begin : g_any
      assign cwp_out = (cwp_in == '0) ? CWPW'(NWIN - 1) : cwp_in - CWPW'(1);
    end
  endgenerate
endmodule

// File: rtl/trap_cache_freeze.sv
module trap_cache_freeze
  import trap_pkg::*;
#(
  parameter int N = NCACHE
) (
  input  logic             is_irq,
  input  logic [N-1:0]     frz_en,
  input  logic [N*CST_W-1:0] ctl_in,
  output logic [N*CST_W-1:0] ctl_out
);
  generate
    for (genvar g = 0; g < N; g++) begin : g_cache
      cstate_t cur;
      assign cur = ctl_in[g*CST_W +: CST_W];
      assign ctl_out[g*CST_W +: CST_W] =
        (is_irq && frz_en[g] && cur == CST_ENABLED) ? CST_FROZEN : cur;
    end
  endgenerate
endmodule

// File: rtl/trap_vector_calc.sv
module trap_vector_calc #(
  parameter int XLEN = 32,
  parameter int TTW  = 8
) (
  input  logic [XLEN-1:0] tbr_in,
  input  logic [TTW-1:0]  tt,
  output logic [XLEN-1:0] tbr_out,
  output logic [XLEN-1:0] vec_pc,
  output logic [XLEN-1:0] vec_npc
);
  localparam int LOWW  = TTW + 4;
  localparam int BASEW = XLEN - LOWW;

  assign tbr_out = {tbr_in[XLEN-1 -: BASEW], tt, 4'h0};
  assign vec_pc  = tbr_out;
  assign vec_npc = tbr_out + XLEN'(4);
endmodule

// File: rtl/trap_entry_seq.sv
module trap_entry_seq
  import trap_pkg::*;
#(
  parameter int NWIN = 8,
  parameter int XLEN = 32,
  parameter int RFAW = 5,
  parameter int CWPW = (NWIN > 1) ? $clog2(NWIN) : 1
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            trap_req,
  input  logic [7:0]      trap_type,
  input  logic            halt_ta0_i,
  input  logic            et_i,
  input  logic            s_i,
  input  logic [CWPW-1:0] cwp_i,
  input  logic [XLEN-1:0] tbr_i,
  input  logic [XLEN-1:0] pc_i,
  input  logic [XLEN-1:0] npc_i,
  input  logic [3:0]      cctl_i,
  input  logic            ifrz_i,
  input  logic            dfrz_i,
  output logic            trap_taken,
  output logic            et_o,
  output logic            s_o,
  output logic            ps_o,
  output logic [CWPW-1:0] cwp_o,
  output logic [XLEN-1:0] tbr_o,
  output logic [XLEN-1:0] pc_o,
  output logic [XLEN-1:0] npc_o,
  output logic [3:0]      cctl_o,
  output logic            rf_we,
  output logic [CWPW-1:0] rf_win,
  output logic [RFAW-1:0] rf_addr_a,
  output logic [XLEN-1:0] rf_data_a,
  output logic [RFAW-1:0] rf_addr_b,
  output logic [XLEN-1:0] rf_data_b,
  output logic            irq_ack,
  output logic [3:0]      irq_level,
  output logic            error_mode,
  output logic            shutdown_req
);
  // ---- combinational helpers ----
  logic [CWPW-1:0] cwp_dec;
  logic [XLEN-1:0] tbr_vec, pc_vec, npc_vec;
  logic [3:0]      cctl_frz;
  logic            is_irq, halted, take, refuse;

  assign is_irq = (trap_type[7:4] == IRQ_GROUP);
  assign halted = error_mode | shutdown_req;
  assign take   = trap_req & ~halted & et_i;
  assign refuse = trap_req & ~halted & ~et_i;

  trap_cwp_dec #(.NWIN(NWIN), .CWPW(CWPW)) u_cwp (
    .cwp_in (cwp_i),
    .cwp_out(cwp_dec)
  );

  trap_vector_calc #(.XLEN(XLEN), .TTW(8)) u_vec (
    .tbr_in (tbr_i),
    .tt     (trap_type),
    .tbr_out(tbr_vec),
    .vec_pc (pc_vec),
    .vec_npc(npc_vec)
  );

  trap_cache_freeze #(.N(NCACHE)) u_frz (
    .is_irq (is_irq),
    .frz_en ({dfrz_i, ifrz_i}),
    .ctl_in (cctl_i),
    .ctl_out(cctl_frz)
  );

  // ---- next state ----
  logic            taken_d, et_d, s_d, ps_d, we_d, ack_d, err_d, shut_d;
  logic [CWPW-1:0] cwp_d;
  logic [XLEN-1:0] tbr_d, pc_d, npc_d, da_d, db_d;
  logic [3:0]      cctl_d, lvl_d;
  logic            state_en;

  assign state_en = take;

  always_comb begin
    taken_d = 1'b0;
    we_d    = 1'b0;
    ack_d   = 1'b0;
    lvl_d   = irq_level;
    et_d    = et_o;
    s_d     = s_o;
    ps_d    = ps_o;
    cwp_d   = cwp_o;
    tbr_d   = tbr_o;
    pc_d    = pc_o;
    npc_d   = npc_o;
    cctl_d  = cctl_o;
    da_d    = rf_data_a;
    db_d    = rf_data_b;
    err_d   = error_mode;
    shut_d  = shutdown_req;
    if (state_en) begin
      taken_d = 1'b1;
      we_d    = 1'b1;
      et_d    = 1'b0;
      ps_d    = s_i;
      s_d     = 1'b1;
      cwp_d   = cwp_dec;
      tbr_d   = tbr_vec;
      pc_d    = pc_vec;
      npc_d   = npc_vec;
      cctl_d  = cctl_frz;
      da_d    = pc_i;
      db_d    = npc_i;
      if (is_irq) begin
        ack_d = 1'b1;
        lvl_d = trap_type[3:0];
      end
    end else if (refuse) begin
      if (trap_type == TT_HALT && halt_ta0_i) shut_d = 1'b1;
      else                                   err_d  = 1'b1;
    end
  end

  // ---- registers ----
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      trap_taken   <= 1'b0;
      rf_we        <= 1'b0;
      irq_ack      <= 1'b0;
      irq_level    <= '0;
      et_o         <= 1'b0;
      s_o          <= 1'b1;
      ps_o         <= 1'b0;
      cwp_o        <= '0;
      tbr_o        <= '0;
      pc_o         <= '0;
      npc_o        <= '0;
      cctl_o       <= '0;
      rf_data_a    <= '0;
      rf_data_b    <= '0;
      error_mode   <= 1'b0;
      shutdown_req <= 1'b0;
    end else begin
      trap_taken   <= taken_d;
      rf_we        <= we_d;
      irq_ack      <= ack_d;
      irq_level    <= lvl_d;
      et_o         <= et_d;
      s_o          <= s_d;
      ps_o         <= ps_d;
      cwp_o        <= cwp_d;
      tbr_o        <= tbr_d;
      pc_o         <= pc_d;
      npc_o        <= npc_d;
      cctl_o       <= cctl_d;
      rf_data_a    <= da_d;
      rf_data_b    <= db_d;
      error_mode   <= err_d;
      shutdown_req <= shut_d;
    end
  end

  assign rf_win    = cwp_o;
  assign rf_addr_a = RFAW'(RF_IDX_PC);
  assign rf_addr_b = RFAW'(RF_IDX_NPC);
endmodule

// File: rtl/trap_entry_chk.sv
module trap_entry_chk #(
  parameter int NWIN = 8,
  parameter int XLEN = 32,
  parameter int CWPW = 3
) (
  input logic            clk,
  input logic            rst_n,
  input logic            trap_req,
  input logic [7:0]      trap_type,
  input logic            et_i,
  input logic [CWPW-1:0] cwp_i,
  input logic            trap_taken,
  input logic            et_o,
  input logic            s_o,
  input logic [CWPW-1:0] cwp_o,
  input logic [XLEN-1:0] tbr_o,
  input logic [XLEN-1:0] pc_o,
  input logic [XLEN-1:0] npc_o,
  input logic            irq_ack,
  input logic            error_mode,
  input logic            shutdown_req
);
  a_r2_et_cleared: assert property (@(posedge clk) disable iff (!rst_n)
    trap_taken |-> !et_o);

  a_r2_from_request: assert property (@(posedge clk) disable iff (!rst_n)
    trap_taken |-> $past(trap_req && et_i));

  a_r3_window_wrap: assert property (@(posedge clk) disable iff (!rst_n)
    trap_taken |-> (int'(cwp_o) ==
      (($past(cwp_i) == '0) ? NWIN - 1 : int'($past(cwp_i)) - 1)));

  a_r5_supervisor: assert property (@(posedge clk) disable iff (!rst_n)
    trap_taken |-> s_o);

  a_r6_vector: assert property (@(posedge clk) disable iff (!rst_n)
    trap_taken |-> (pc_o == tbr_o) && (npc_o == pc_o + XLEN'(4)));

  a_r7_ack_group: assert property (@(posedge clk) disable iff (!rst_n)
    irq_ack |-> trap_taken && ($past(trap_type[7:4]) == 4'h1));

  a_r9_refused: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(error_mode) |-> !trap_taken && $past(trap_req && !et_i));

  a_r10_error_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    error_mode |=> error_mode);

  a_r10_shut_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    shutdown_req |=> shutdown_req);

  a_r10_no_take_halted: assert property (@(posedge clk) disable iff (!rst_n)
    (error_mode || shutdown_req) |=> !trap_taken);
endmodule

bind trap_entry_seq trap_entry_chk #(.NWIN(NWIN), .XLEN(XLEN), .CWPW(CWPW)) u_chk (
  .clk(clk), .rst_n(rst_n), .trap_req(trap_req), .trap_type(trap_type),
  .et_i(et_i), .cwp_i(cwp_i), .trap_taken(trap_taken), .et_o(et_o),
  .s_o(s_o), .cwp_o(cwp_o), .tbr_o(tbr_o), .pc_o(pc_o), .npc_o(npc_o),
  .irq_ack(irq_ack), .error_mode(error_mode), .shutdown_req(shutdown_req)
);

// File: tb/tb_trap_entry_seq.sv
`timescale 1ns/1ps
module tb_trap_entry_seq;
  localparam int NWIN = 8;
  localparam int XLEN = 32;
  localparam int RFAW = 5;
  localparam int CWPW = 3;

  logic clk = 1'b0;
  always #2.5 clk = ~clk;

  logic            rst_n;
  logic            trap_req, halt_ta0_i, et_i, s_i, ifrz_i, dfrz_i;
  logic [7:0]      trap_type;
  logic [CWPW-1:0] cwp_i;
  logic [XLEN-1:0] tbr_i, pc_i, npc_i;
  logic [3:0]      cctl_i;
  logic            trap_taken, et_o, s_o, ps_o, rf_we, irq_ack, error_mode, shutdown_req;
  logic [CWPW-1:0] cwp_o, rf_win;
  logic [XLEN-1:0] tbr_o, pc_o, npc_o, rf_data_a, rf_data_b;
  logic [3:0]      cctl_o, irq_level;
  logic [RFAW-1:0] rf_addr_a, rf_addr_b;

  trap_entry_seq #(.NWIN(NWIN), .XLEN(XLEN), .RFAW(RFAW)) dut (.*);

  int checks = 0, failures = 0;
  bit done = 0, cmp_on = 0;

  // ---- behavioural reference model ----
  logic m_taken, m_et, m_s, m_ps, m_we, m_ack, m_err, m_shut;
  int   m_cwp, m_lvl;
  logic [XLEN-1:0] m_tbr, m_pc, m_npc, m_da, m_db;
  logic [3:0] m_cctl;

  function automatic logic [1:0] frz(logic [1:0] st, logic en, logic irq);
    return (irq && en && st == 2'b11) ? 2'b01 : st;
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_taken = 0; m_we = 0; m_ack = 0; m_lvl = 0; m_et = 0; m_s = 1; m_ps = 0;
      m_cwp = 0; m_tbr = 0; m_pc = 0; m_npc = 0; m_cctl = 0; m_da = 0; m_db = 0;
      m_err = 0; m_shut = 0;
    end else begin
      m_taken = 0; m_we = 0; m_ack = 0;
      if (trap_req && !m_err && !m_shut) begin
        if (et_i) begin
          automatic bit irq = (trap_type / 16 == 1);
          m_taken = 1; m_we = 1; m_et = 0; m_ps = s_i; m_s = 1;
          m_cwp = (int'(cwp_i) + NWIN - 1) % NWIN;
          m_tbr = (tbr_i & 32'hFFFF_F000) | (32'(trap_type) * 16);
          m_pc = m_tbr; m_npc = m_tbr + 4; m_da = pc_i; m_db = npc_i;
          m_cctl = {frz(cctl_i[3:2], dfrz_i, irq), frz(cctl_i[1:0], ifrz_i, irq)};
          if (irq) begin m_ack = 1; m_lvl = trap_type % 16; end
        end else if (trap_type == 8'h80 && halt_ta0_i) m_shut = 1;
        else m_err = 1;
      end
    end
  end

  task automatic chk(string req, string what, longint act, longint exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s %s actual=%0h expected=%0h at %0t", req, what, act, exp, $time);
    end
  endtask

  always @(negedge clk) if (cmp_on && !done) begin
    chk("R2", "trap_taken", trap_taken, m_taken);
    chk("R2", "et_o", et_o, m_et);
    chk("R5", "s_o", s_o, m_s);
    chk("R5", "ps_o", ps_o, m_ps);
    chk("R3", "cwp_o", cwp_o, m_cwp);
    chk("R4", "rf_we", rf_we, m_we);
    chk("R4", "rf_win", rf_win, m_cwp);
    chk("R4", "rf_addr_a", rf_addr_a, 9);
    chk("R4", "rf_addr_b", rf_addr_b, 10);
    chk("R4", "rf_data_a", rf_data_a, m_da);
    chk("R4", "rf_data_b", rf_data_b, m_db);
    chk("R6", "tbr_o", tbr_o, m_tbr);
    chk("R6", "pc_o", pc_o, m_pc);
    chk("R6", "npc_o", npc_o, m_npc);
    chk("R7", "irq_ack", irq_ack, m_ack);
    chk("R7", "irq_level", irq_level, m_lvl);
    chk("R8", "cctl_o", cctl_o, m_cctl);
    chk("R9", "error_mode", error_mode, m_err);
    chk("R9", "shutdown_req", shutdown_req, m_shut);
  end

  task automatic idle(int n);
    for (int i = 0; i < n; i++) begin @(negedge clk); trap_req = 0; end
  endtask

  task automatic trap(logic et, logic s, int cwp, logic [31:0] tbr, logic [7:0] tt,
                      logic [3:0] cc, logic fi, logic fd);
    @(negedge clk);
    trap_req = 1; et_i = et; s_i = s; cwp_i = CWPW'(cwp); tbr_i = tbr; trap_type = tt;
    cctl_i = cc; ifrz_i = fi; dfrz_i = fd;
    pc_i = 32'h4000_0000 + 32'(cwp) * 32'h100 + 32'(tt);
    npc_i = pc_i + 4;
  endtask

  task automatic do_reset();
    @(negedge clk); rst_n = 0; trap_req = 0;
    idle(2);
    // R1: reset values held during and right after reset
    chk("R1", "s_o reset", s_o, 1);
    chk("R1", "et_o reset", et_o, 0);
    chk("R1", "cwp_o reset", cwp_o, 0);
    chk("R1", "strobes reset", {trap_taken, rf_we, irq_ack, error_mode, shutdown_req}, 0);
    @(negedge clk); rst_n = 1;
  endtask

  initial begin
    rst_n = 0; trap_req = 0; halt_ta0_i = 0; et_i = 0; s_i = 0; ifrz_i = 0; dfrz_i = 0;
    trap_type = 0; cwp_i = 0; tbr_i = 0; pc_i = 0; npc_i = 0; cctl_i = 0;
    do_reset();
    cmp_on = 1;
    idle(2);
    // R2/R3 wrap, R5, R6 basic traps
    trap(1, 0, 0, 32'hABCD_E123, 8'h05, 4'h0, 0, 0);
    trap(1, 1, 5, 32'h1234_5FFF, 8'h80, 4'hF, 1, 1);  // non-irq: R8 no freeze
    idle(1);
    // R7/R8 interrupt cases
    trap(1, 0, 3, 32'h0000_1000, 8'h1A, 4'hF, 1, 0);  // icache frozen -> D
    trap(1, 1, 7, 32'h0000_2000, 8'h1F, 4'hF, 0, 1);  // dcache frozen -> 7
    trap(1, 1, 1, 32'h0000_3000, 8'h10, 4'b0110, 1, 1); // not enabled: unchanged
    trap(1, 0, 2, 32'h0000_4000, 8'h13, 4'b1101, 1, 1); // data only enabled
    trap(1, 1, 4, 32'h0000_5000, 8'h20, 4'hF, 1, 1);  // group 2: no ack
    // R11 hold
    idle(4);
    // pseudo-random taken traps
    begin
      logic [31:0] x = 32'h1357_9BDF;
      for (int k = 0; k < 60; k++) begin
        x ^= x << 13; x ^= x >> 17; x ^= x << 5;
        trap(1, x[0], int'(x[10:8]) % NWIN, x, x[23:16], x[27:24], x[28], x[29]);
        if (x[30]) idle(1);
      end
    end
    idle(2);
    // R9 error, R10 ignored afterwards
    trap(0, 0, 3, 32'h0000_6000, 8'h07, 4'h0, 0, 0);
    trap(1, 0, 3, 32'h0000_7000, 8'h11, 4'hF, 1, 1);
    idle(3);
    // R9 shutdown path from fresh reset
    cmp_on = 0;
    do_reset();
    cmp_on = 1;
    halt_ta0_i = 1;
    trap(0, 1, 0, 32'h0000_8000, 8'h80, 4'h0, 0, 0);
    trap(1, 0, 6, 32'h0000_9000, 8'h12, 4'hF, 1, 1);  // R10 ignored
    idle(3);
    // R9 halt feature on but type not 0x80 -> error
    cmp_on = 0;
    do_reset();
    cmp_on = 1;
    trap(0, 1, 0, 32'h0000_A000, 8'h81, 4'h0, 0, 0);
    idle(3);
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    #(5.0 * 200000);
    if (!done) begin
      done = 1;
      checks++; failures++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule